// File: doc/BRIEF.md
# Load/Store Watchpoint Qualification Unit

This unit produces load/store debug watchpoints for a processor core. On every cycle that flags a valid load/store access, it checks three things for each of two independent channels. The first is one selected instruction watchpoint. The second is a pair of address equality comparators (E, F). The third is a pair of data equality comparators (G, H). Each comparator compares the access against a value held in its own register.

Each channel chooses which instruction watchpoint counts and how to combine each comparator pair. A separate care bit for each condition can turn that condition into "always satisfied". When a channel matches, it can raise a software trap, a development-port trap, or both. A global rule gates these traps: traps are recognized only while the recoverable-interrupt flag is set, unless the non-mask bit forces them on.

Software sets up the unit through one 32-bit control word and a value-register write port. Only a separate debug-side strobe can change the development-port trap enables.

Top module: `lswatch_unit`

## Requirements
- R1: A channel's trap rises only when its instruction condition, address condition and data condition all hold during the same valid access.
- R2: Channel field bits [2:1] select the instruction watchpoint input `iwp_hit[isel]`: 0 selects bit 0, 1 selects bit 1, 2 selects bit 2, 3 selects bit 3.
- R3: Channel field bits [5:4] select the address event: 0 selects E, 1 selects F, 2 selects E AND F, 3 selects E OR F. E is true when `acc_addr` equals value register 0. F is true when it equals value register 1.
- R4: Channel field bits [8:7] select the data event: 0 selects G, 1 selects H, 2 selects G AND H, 3 selects G OR H. G is true when `acc_data` equals value register 2. H is true when it equals value register 3.
- R5: Care bits sit at channel field bits 3 (instruction), 6 (address) and 9 (data). A 0 makes that condition satisfied whatever the selected event is. A 1 requires the selected event.
- R6: Channel field bit 0 enables the channel. A disabled channel never traps.
- R7: Control bit 20 is the non-mask bit. When it is 0, traps are raised only if `msr_ri` was 1 during the access. When it is 1, `msr_ri` is ignored.
- R8: Control bits 27:26 are the software trap enables and bits 25:24 the development-port trap enables, one bit per channel (channel 0 in the lower bit). A trap output rises only if its own enable bit is set. Only `dbg_we` with `dbg_wdata` loads bits 25:24, and `cfg_we` leaves them unchanged.
- R9: Trap outputs are registered. An access sampled at one rising edge drives the traps from that edge until the next edge. After an edge with `acc_valid` low, the traps are 0.
- R10: After reset, `cfg_rdata` and all trap outputs are 0. Reserved control bits 23:21 and 31:28 always read 0.
- R11: Channel 0 uses control bits 9:0 and channel 1 uses bits 19:10. Each channel's traps depend only on its own field and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word readback |
| dbg_we | input | 1 | Debug-side write strobe for development-port trap enables |
| dbg_wdata | input | 2 | Development-port trap enables, one per channel |
| val_we | input | 1 | Comparator value write strobe |
| val_idx | input | 2 | Value register index: 0=E, 1=F, 2=G, 3=H |
| val_wdata | input | 32 | Comparator value write data |
| acc_valid | input | 1 | Load/store access valid this cycle |
| acc_addr | input | 32 | Access address |
| acc_data | input | 32 | Access data |
| iwp_hit | input | 4 | Instruction watchpoint match inputs |
| msr_ri | input | 1 | Machine-state recoverable-interrupt flag |
| sw_trap | output | 2 | Software trap per channel |
| dev_trap | output | 2 | Development-port trap per channel |

## Verification
The unit holds no state except its programmed registers and the trap flops. A wrong select decode, care bit, enable or value register therefore shows as a wrong trap bit one clock after the first access that exercises it. A wrong register bit also shows at once on `cfg_rdata`. The sweep runs every channel field value against every comparator combination, including cases where both comparators of a pair match together. Because of this, a swapped select code or a flipped care polarity appears within a few accesses of the configuration that depends on it.

// File: rtl/lswatch_pkg.sv
package lswatch_pkg;
   localparam int CH_FW      = 10;
   localparam int CTRL_W     = 32;
   localparam int NOMASK_BIT = 20;
   localparam int DEV_LSB    = 24;
   localparam int SW_LSB     = 26;
   localparam int IWP_N      = 4;
   localparam int SEL_W      = 2;

   typedef struct packed {
      logic             dcare;
      logic [SEL_W-1:0] dsel;
      logic             acare;
      logic [SEL_W-1:0] asel;
      logic             icare;
      logic [SEL_W-1:0] isel;
      logic             en;
   } chan_cfg_t;

   function automatic logic pair_event(input logic [SEL_W-1:0] sel, input logic a, input logic b);
      case (sel)
         2'd0:    return a;
         2'd1:    return b;
         2'd2:    return a & b;
         default: return a | b;
      endcase
   endfunction
endpackage

// File: rtl/lswatch_cmp.sv
module lswatch_cmp #(
   parameter int W = 32
) (
   input  logic [W-1:0] probe,
   input  logic [W-1:0] ref_a,
   input  logic [W-1:0] ref_b,
   output logic         hit_a,
   output logic         hit_b
);
   assign hit_a = (probe == ref_a);
   assign hit_b = (probe == ref_b);
endmodule

// File: rtl/lswatch_regs.sv
module lswatch_regs
   import lswatch_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int VAL_W  = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [CTRL_W-1:0]        cfg_wdata,
   input  logic                     dbg_we,
   input  logic [NUM_CH-1:0]        dbg_wdata,
   input  logic                     val_we,
   input  logic [1:0]               val_idx,
   input  logic [VAL_W-1:0]         val_wdata,
   output chan_cfg_t [NUM_CH-1:0]   ch_cfg,
   output logic                     nomask,
   output logic [NUM_CH-1:0]        sw_en,
   output logic [NUM_CH-1:0]        dev_en,
   output logic [ADDR_W-1:0]        e_val,
   output logic [ADDR_W-1:0]        f_val,
   output logic [DATA_W-1:0]        g_val,
   output logic [DATA_W-1:0]        h_val,
   output logic [CTRL_W-1:0]        cfg_rdata
);
   localparam int CHB = NUM_CH * CH_FW;

   logic [CHB-1:0]    ch_q;
   logic              nomask_q;
   logic [NUM_CH-1:0] sw_q;
   logic [NUM_CH-1:0] dev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_q     <= '0;
         nomask_q <= 1'b0;
         sw_q     <= '0;
      end else if (cfg_we) begin
         ch_q     <= cfg_wdata[CHB-1:0];
         nomask_q <= cfg_wdata[NOMASK_BIT];
         sw_q     <= cfg_wdata[SW_LSB +: NUM_CH];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dev_q <= '0;
      else if (dbg_we) dev_q <= dbg_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_val <= '0;
         f_val <= '0;
         g_val <= '0;
         h_val <= '0;
      end else if (val_we) begin
         case (val_idx)
            2'd0:    e_val <= val_wdata[ADDR_W-1:0];
            2'd1:    f_val <= val_wdata[ADDR_W-1:0];
            2'd2:    g_val <= val_wdata[DATA_W-1:0];
            default: h_val <= val_wdata[DATA_W-1:0];
         endcase
      end
   end

   assign ch_cfg = ch_q;
   assign nomask = nomask_q;
   assign sw_en  = sw_q;
   assign dev_en = dev_q;

   always_comb begin
      cfg_rdata                    = '0;
      cfg_rdata[CHB-1:0]           = ch_q;
      cfg_rdata[NOMASK_BIT]        = nomask_q;
      cfg_rdata[DEV_LSB +: NUM_CH] = dev_q;
      cfg_rdata[SW_LSB +: NUM_CH]  = sw_q;
   end
endmodule

// File: rtl/lswatch_chan.sv
module lswatch_chan
   import lswatch_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chan_cfg_t        cfg,
   input  logic [IWP_N-1:0] iwp_hit,
   input  logic             hit_e,
   input  logic             hit_f,
   input  logic             hit_g,
   input  logic             hit_h,
   input  logic             acc_valid,
   input  logic             recog,
   input  logic             sw_en,
   input  logic             dev_en,
   output logic             sw_trap,
   output logic             dev_trap
);
   logic i_ok, a_ok, d_ok, wp, sw_d, dev_d;

   assign i_ok  = ~cfg.icare | iwp_hit[cfg.isel];
   assign a_ok  = ~cfg.acare | pair_event(cfg.asel, hit_e, hit_f);
   assign d_ok  = ~cfg.dcare | pair_event(cfg.dsel, hit_g, hit_h);
   assign wp    = acc_valid & cfg.en & i_ok & a_ok & d_ok;
   assign sw_d  = wp & recog & sw_en;
   assign dev_d = wp & recog & dev_en;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sw_trap  <= 1'b0;
               dev_trap <= 1'b0;
            end else begin
               sw_trap  <= sw_d;
               dev_trap <= dev_d;
            end
         end
      end else begin : g_comb
         assign sw_trap  = sw_d;
         assign dev_trap = dev_d;
      end
   endgenerate
endmodule

// File: rtl/lswatch_unit.sv
module lswatch_unit
   import lswatch_pkg::*;
#(
   parameter int NUM_CH  = 2,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1,
   localparam int VAL_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CTRL_W-1:0]  cfg_wdata,
   output logic [CTRL_W-1:0]  cfg_rdata,
   input  logic               dbg_we,
   input  logic [NUM_CH-1:0]  dbg_wdata,
   input  logic               val_we,
   input  logic [1:0]         val_idx,
   input  logic [VAL_W-1:0]   val_wdata,
   input  logic               acc_valid,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [DATA_W-1:0]  acc_data,
   input  logic [IWP_N-1:0]   iwp_hit,
   input  logic               msr_ri,
   output logic [NUM_CH-1:0]  sw_trap,
   output logic [NUM_CH-1:0]  dev_trap
);
   generate
      if (NUM_CH != 2) begin : g_bad_ch
         $error("lswatch_unit: control word layout holds exactly two channels");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("lswatch_unit: widths must be positive");
      end
      if (NUM_CH * CH_FW > NOMASK_BIT) begin : g_bad_fit
         $error("lswatch_unit: channel fields overlap the global bits");
      end
   endgenerate

   chan_cfg_t [NUM_CH-1:0] ch_cfg;
   logic                   nomask, recog;
   logic [NUM_CH-1:0]      sw_en, dev_en;
   logic [ADDR_W-1:0]      e_val, f_val;
   logic [DATA_W-1:0]      g_val, h_val;
   logic                   hit_e, hit_f, hit_g, hit_h;

   lswatch_regs #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VAL_W(VAL_W)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
      .val_we(val_we), .val_idx(val_idx), .val_wdata(val_wdata),
      .ch_cfg(ch_cfg), .nomask(nomask), .sw_en(sw_en), .dev_en(dev_en),
      .e_val(e_val), .f_val(f_val), .g_val(g_val), .h_val(h_val),
      .cfg_rdata(cfg_rdata)
   );

   lswatch_cmp #(.W(ADDR_W)) acmp_i (
      .probe(acc_addr), .ref_a(e_val), .ref_b(f_val), .hit_a(hit_e), .hit_b(hit_f)
   );

   lswatch_cmp #(.W(DATA_W)) dcmp_i (
      .probe(acc_data), .ref_a(g_val), .ref_b(h_val), .hit_a(hit_g), .hit_b(hit_h)
   );

   assign recog = nomask | msr_ri;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         lswatch_chan #(.OUT_REG(OUT_REG)) chan_i (
            .clk(clk), .rst_n(rst_n), .cfg(ch_cfg[c]), .iwp_hit(iwp_hit),
            .hit_e(hit_e), .hit_f(hit_f), .hit_g(hit_g), .hit_h(hit_h),
            .acc_valid(acc_valid), .recog(recog),
            .sw_en(sw_en[c]), .dev_en(dev_en[c]),
            .sw_trap(sw_trap[c]), .dev_trap(dev_trap[c])
         );
      end
   endgenerate
endmodule

// File: rtl/lswatch_chk.sv
module lswatch_chk
   import lswatch_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              msr_ri,
   input logic              dbg_we,
   input logic [CTRL_W-1:0] cfg_rdata,
   input logic [NUM_CH-1:0] sw_trap,
   input logic [NUM_CH-1:0] dev_trap
);
   a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[23:21] == 3'b000 && cfg_rdata[31:28] == 4'b0000);

   a_r8_dev_only_debug: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_we |=> $stable(cfg_rdata[DEV_LSB +: NUM_CH]));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      a_r9_trap_after_access: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_trap[c] || dev_trap[c]) |-> $past(acc_valid));

      a_r6_trap_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_trap[c] || dev_trap[c]) |-> $past(cfg_rdata[c*CH_FW]));

      a_r7_recognized: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_trap[c] || dev_trap[c]) |-> $past(msr_ri || cfg_rdata[NOMASK_BIT]));

      a_r8_sw_gate: assert property (@(posedge clk) disable iff (!rst_n)
         sw_trap[c] |-> $past(cfg_rdata[SW_LSB + c]));

      a_r8_dev_gate: assert property (@(posedge clk) disable iff (!rst_n)
         dev_trap[c] |-> $past(cfg_rdata[DEV_LSB + c]));
   end
endmodule

bind lswatch_unit lswatch_chk #(.NUM_CH(NUM_CH)) chk_i (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .msr_ri(msr_ri),
   .dbg_we(dbg_we), .cfg_rdata(cfg_rdata), .sw_trap(sw_trap), .dev_trap(dev_trap)
);

// File: tb/lswatch_unit_tb_top.sv
module lswatch_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        dbg_we = 1'b0;
   logic [1:0]  dbg_wdata = '0;
   logic        val_we = 1'b0;
   logic [1:0]  val_idx = '0;
   logic [31:0] val_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [31:0] acc_data = '0;
   logic [3:0]  iwp_hit = '0;
   logic        msr_ri = 1'b0;
   logic [1:0]  sw_trap, dev_trap;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [31:0] ev, fv, gv, hv;
   logic [9:0]  fld0, fld1;
   logic        nm;
   logic [1:0]  swe, deve;

   always #10 clk = ~clk;

   lswatch_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
      .val_we(val_we), .val_idx(val_idx), .val_wdata(val_wdata),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_data(acc_data),
      .iwp_hit(iwp_hit), .msr_ri(msr_ri), .sw_trap(sw_trap), .dev_trap(dev_trap)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic logic pick(input logic [1:0] s, input logic a, input logic b);
      case (s)
         2'd0: return a;
         2'd1: return b;
         2'd2: return a & b;
         default: return a | b;
      endcase
   endfunction

   // field: [0]en [2:1]isel [3]icare [5:4]asel [6]acare [8:7]dsel [9]dcare
   function automatic logic model_wp(input logic [9:0] f, input logic [3:0] iw,
                                     input logic e, input logic ff, input logic g, input logic h);
      logic i_ok, a_ok, d_ok;
      i_ok = !f[3] || iw[f[2:1]];
      a_ok = !f[6] || pick(f[5:4], e, ff);
      d_ok = !f[9] || pick(f[8:7], g, h);
      return f[0] && i_ok && a_ok && d_ok;
   endfunction

   function automatic logic [9:0] fld_of(input logic [9:0] k);
      return {k[8], k[7:6], k[5], k[4:3], k[2], k[1:0], k[9]};
   endfunction

   task automatic write_cfg(input logic [31:0] w);
      cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic write_val(input logic [1:0] idx, input logic [31:0] w);
      val_we = 1'b1; val_idx = idx; val_wdata = w;
      @(negedge clk);
      val_we = 1'b0;
   endtask

   task automatic program_all();
      write_cfg({4'b0, swe, 2'b11, 3'b111, nm, fld1, fld0});
   endtask

   task automatic access(input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] iw, input logic ri, input string tag);
      logic e, ff, g, h, w0, w1, rc;
      acc_valid = 1'b1; acc_addr = a; acc_data = d; iwp_hit = iw; msr_ri = ri;
      e = (a == ev); ff = (a == fv); g = (d == gv); h = (d == hv);
      w0 = model_wp(fld0, iw, e, ff, g, h);
      w1 = model_wp(fld1, iw, e, ff, g, h);
      rc = nm | ri;
      @(negedge clk);
      acc_valid = 1'b0;
      check({tag, " sw0"},  {31'b0, sw_trap[0]},  {31'b0, w0 & rc & swe[0]});
      check({tag, " sw1"},  {31'b0, sw_trap[1]},  {31'b0, w1 & rc & swe[1]});
      check({tag, " dev0"}, {31'b0, dev_trap[0]}, {31'b0, w0 & rc & deve[0]});
      check({tag, " dev1"}, {31'b0, dev_trap[1]}, {31'b0, w1 & rc & deve[1]});
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] a_sel [3];
      logic [31:0] d_sel [3];
      repeat (2) @(negedge clk);
      // R10: reset state
      check("R10 reset cfg_rdata", cfg_rdata, 32'h0);
      check("R10 reset traps", {28'b0, dev_trap, sw_trap}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      ev = 32'h1000_0040; fv = 32'h2000_0080; gv = 32'hDEAD_0001; hv = 32'hBEEF_0002;
      write_val(2'd0, ev); write_val(2'd1, fv); write_val(2'd2, gv); write_val(2'd3, hv);

      // R8: development enables only via debug strobe
      dbg_we = 1'b1; dbg_wdata = 2'b01;
      @(negedge clk);
      dbg_we = 1'b0;
      deve = 2'b01;
      write_cfg(32'hFFFF_FFFF);
      check("R8 dev bits unchanged by cfg write", {30'b0, cfg_rdata[25:24]}, 32'h1);
      check("R10 reserved read zero", {25'b0, cfg_rdata[31:28], cfg_rdata[23:21]}, 32'h0);
      check("R11 all fields written", {12'b0, cfg_rdata[19:0]}, 32'h000F_FFFF);
      check("R8 sw bits written", {30'b0, cfg_rdata[27:26]}, 32'h3);

      // R9: no trap without a valid access even when everything matches
      acc_addr = ev; acc_data = gv; iwp_hit = 4'hF; msr_ri = 1'b1;
      @(negedge clk);
      check("R9 idle no sw trap", {30'b0, sw_trap}, 32'h0);
      check("R9 idle no dev trap", {30'b0, dev_trap}, 32'h0);

      a_sel[0] = ev; a_sel[1] = fv; a_sel[2] = 32'h3000_00C0;
      d_sel[0] = gv; d_sel[1] = hv; d_sel[2] = 32'h0000_0000;

      // Phase A: distinct comparator values, R1 R2 R3 R4 R5 R6 R7 R8 R11
      for (int k = 0; k < 1024; k++) begin
         logic [9:0] kk;
         kk = k[9:0];
         fld0 = fld_of(kk);
         fld1 = fld_of(kk ^ 10'h155);
         nm = kk[0] ^ kk[5];
         swe = {kk[2] ^ kk[6], 1'b1};
         program_all();
         for (int p = 0; p < 18; p++) begin
            logic [3:0] iw;
            logic [3:0] oh;
            oh = 4'b0001 << fld0[2:1];
            iw = (p >= 9) ? ~oh : oh;
            access(a_sel[p % 3], d_sel[(p / 3) % 3], iw, p[0] ^ kk[1],
                   "R1 R2 R3 R4 R5 R6 R7 R8 R11 sweepA");
         end
      end

      // Phase B: paired comparators equal so AND forms can hold (R3 R4)
      fv = ev; hv = gv;
      write_val(2'd1, fv); write_val(2'd3, hv);
      for (int k = 0; k < 1024; k++) begin
         logic [9:0] kk;
         kk = k[9:0];
         fld0 = fld_of(kk);
         fld1 = fld_of(~kk);
         nm = kk[3];
         swe = {kk[4], kk[7] | kk[0]};
         program_all();
         for (int p = 0; p < 8; p++) begin
            logic [3:0] oh;
            oh = 4'b0001 << fld0[2:1];
            access(p[0] ? ev : 32'h3000_00C0, p[1] ? gv : 32'h5555_0000,
                   p[2] ? ~oh : oh, kk[8] ^ p[0], "R1 R3 R4 R5 R7 sweepB");
         end
      end

      // R9: traps fall after an idle edge
      fld0 = 10'h001; fld1 = 10'h001; nm = 1'b1; swe = 2'b11;
      program_all();
      access(32'h0, 32'h0, 4'h0, 1'b0, "R9 single access");
      @(negedge clk);
      check("R9 trap cleared after idle edge", {28'b0, dev_trap, sw_trap}, 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule